// File: doc/BRIEF.md
# Pipeline Exception Control Unit

This block sits next to a five-stage in-order pipeline and turns exception requests from two stages into a precise exception. The decode stage can report an undefined opcode. The execute stage can report an arithmetic overflow. Each request arrives with that stage's program counter and a flag that says the slot holds a real instruction rather than a bubble. When a request is accepted, the unit does four things in the same cycle:

- it picks the oldest faulting instruction;
- it raises flush controls for that instruction's stage and every younger stage;
- for an overflow, it blocks the faulting instruction's register write;
- it steers fetch to a handler entry.

At the clock edge that ends that cycle, the unit stores the faulting PC plus 4 and a one-bit cause code. Both stored values are exposed to the datapath as read ports. Handler software subtracts the 4 itself.

The `VECTORED` parameter chooses the handler entry scheme. When it is 0, every exception enters at 0x8000_0180. When it is 1, the entry is 0xC000_0000 plus 0x20 times the cause code.

Inside the unit, the choice is held in an enumerated selector with three named values:

- `SEL_NONE`: no exception is accepted.
- `SEL_EX`: the execute-stage overflow is accepted.
- `SEL_ID`: the decode-stage undefined opcode is accepted.

A `unique case` on the selector drives the flush outputs and the write-blocking output. The stored EPC and cause have two behaviours: they hold their value while the selector is `SEL_NONE`, and they load new values while it is `SEL_EX` or `SEL_ID`.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, `epc_q` and `cause_q` are zero. With no request and no branch, `redirect`, `flush_if`, `flush_id`, `flush_ex` and `ex_wb_suppress` are all low.
- R2: When `ex_valid` and `ex_ovf` are both high, the following happen in that same cycle: `flush_if`, `flush_id`, `flush_ex` and `ex_wb_suppress` go high, and `redirect` goes high. After the next clock edge, `cause_q` is 1 and `epc_q` is `ex_pc` + 4, computed modulo 2^32.
- R3: When `id_valid` and `id_undef` are high and no execute exception is accepted, the following happen in that same cycle: `flush_if` and `flush_id` go high, while `flush_ex` and `ex_wb_suppress` stay low. After the next clock edge, `cause_q` is 0 and `epc_q` is `id_pc` + 4.
- R4: When both stages raise an exception in the same cycle, only the execute-stage exception (the older instruction) is taken. Its cause (1) and its PC + 4 are recorded, and all three flushes are raised.
- R5: A request whose stage valid flag is low is ignored. It causes no redirect and no flush, and `epc_q` and `cause_q` do not change.
- R6: With `VECTORED`=0, `redirect_pc` is 0x8000_0180 for every accepted exception.
- R7: With `VECTORED`=1, `redirect_pc` is 0xC000_0000 for cause 0 and 0xC000_0020 for cause 1.
- R8: An accepted exception overrides a branch redirect raised in the same cycle. In that case `redirect_pc` is the handler entry, not `br_target`.
- R9: A branch redirect with no accepted exception sets `redirect` high and `redirect_pc` to `br_target`. All flush outputs stay low.
- R10: `epc_q` and `cause_q` keep their values in every cycle where no exception is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_undef | input | 1 | Decode found an undefined opcode |
| id_pc | input | 32 | PC of the decode-stage instruction |
| ex_valid | input | 1 | Execute slot holds a real instruction |
| ex_ovf | input | 1 | Execute found an arithmetic overflow |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| br_redirect | input | 1 | Branch unit requests a fetch redirect |
| br_target | input | 32 | Branch target address |
| redirect | output | 1 | Fetch must load `redirect_pc` |
| redirect_pc | output | 32 | Next fetch address |
| flush_if | output | 1 | Turn the IF pipeline register into a bubble |
| flush_id | output | 1 | Turn the ID pipeline register into a bubble |
| flush_ex | output | 1 | Turn the EX pipeline register into a bubble |
| ex_wb_suppress | output | 1 | Block the execute instruction's register write |
| epc_q | output | 32 | Stored faulting PC + 4 |
| cause_q | output | 1 | Stored cause (0 undefined opcode, 1 overflow) |

## Verification
Three pairs of functions can coincide in one cycle:

- **Decode and execute faults together.** The bench raises a decode fault and an execute fault in the same cycle. It then checks that only the execute fault's cause and PC + 4 are stored, and that all three flushes are high.
- **Exception and branch redirect together.** The bench raises a branch redirect in the same cycle as an exception. It then checks that the handler entry, not the branch target, reaches `redirect_pc`.
- **Bubble and fault together.** The bench sets a fault flag on a slot whose valid flag is low. It then checks that the following idle cycle shows the stored registers unchanged.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_EX   = 2'd1,
        SEL_ID   = 2'd2
    } exc_sel_e;

    localparam int CODE_UNDEF = 0;
    localparam int CODE_OVF   = 1;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 1
) (
    input  logic               id_valid,
    input  logic               id_undef,
    input  logic [XLEN-1:0]    id_pc,
    input  logic               ex_valid,
    input  logic               ex_ovf,
    input  logic [XLEN-1:0]    ex_pc,
    output exc_sel_e           sel,
    output logic               take,
    output logic [XLEN-1:0]    win_pc,
    output logic [CAUSE_W-1:0] win_cause
);
    logic ex_req;
    logic id_req;

    assign ex_req = ex_valid & ex_ovf;
    assign id_req = id_valid & id_undef;

    // The execute stage holds the older instruction, so it wins.
    always_comb begin
        if (ex_req)      sel = SEL_EX;
        else if (id_req) sel = SEL_ID;
        else             sel = SEL_NONE;
    end

    always_comb begin
        take      = 1'b0;
        win_pc    = '0;
        win_cause = '0;
        unique case (sel)
            SEL_EX: begin
                take      = 1'b1;
                win_pc    = ex_pc;
                win_cause = CAUSE_W'(CODE_OVF);
            end
            SEL_ID: begin
                take      = 1'b1;
                win_pc    = id_pc;
                win_cause = CAUSE_W'(CODE_UNDEF);
            end
            default: begin
                take      = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
    parameter int          XLEN        = 32,
    parameter int          CAUSE_W     = 1,
    parameter bit          VECTORED    = 1'b0,
    parameter logic [31:0] FIXED_ENTRY = 32'h8000_0180,
    parameter logic [31:0] VEC_BASE    = 32'hC000_0000,
    parameter int          STRIDE_SH   = 5
) (
    input  logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    entry
);
    generate
        if (VECTORED) begin : g_vec
            logic [XLEN-1:0] offset;
            assign offset = XLEN'(cause) << STRIDE_SH;
            assign entry  = XLEN'(VEC_BASE) + offset;
        end else begin : g_fixed
            logic unused_cause;
            assign unused_cause = ^cause;
            assign entry        = XLEN'(FIXED_ENTRY);
        end
    endgenerate
endmodule

// File: rtl/exc_regs.sv
module exc_regs #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [XLEN-1:0]    pc_in,
    input  logic [CAUSE_W-1:0] cause_in,
    output logic [XLEN-1:0]    epc_q,
    output logic [CAUSE_W-1:0] cause_q
);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (wr_en) begin
            epc_q   <= pc_in + PC_STEP;
            cause_q <= cause_in;
        end
    end
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter bit          VECTORED    = 1'b0,
    parameter logic [31:0] FIXED_ENTRY = 32'h8000_0180,
    parameter logic [31:0] VEC_BASE    = 32'hC000_0000,
    parameter int          STRIDE_SH   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_valid,
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            ex_valid,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    input  logic            br_redirect,
    input  logic [XLEN-1:0] br_target,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic            flush_if,
    output logic            flush_id,
    output logic            flush_ex,
    output logic            ex_wb_suppress,
    output logic [XLEN-1:0] epc_q,
    output logic [0:0]      cause_q
);
    localparam int CAUSE_W = 1;

    exc_sel_e           sel;
    logic               take;
    logic [XLEN-1:0]    win_pc;
    logic [CAUSE_W-1:0] win_cause;
    logic [XLEN-1:0]    entry;

    exc_arbiter #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_arb (
        .id_valid  (id_valid),
        .id_undef  (id_undef),
        .id_pc     (id_pc),
        .ex_valid  (ex_valid),
        .ex_ovf    (ex_ovf),
        .ex_pc     (ex_pc),
        .sel       (sel),
        .take      (take),
        .win_pc    (win_pc),
        .win_cause (win_cause)
    );

    exc_vector_gen #(
        .XLEN        (XLEN),
        .CAUSE_W     (CAUSE_W),
        .VECTORED    (VECTORED),
        .FIXED_ENTRY (FIXED_ENTRY),
        .VEC_BASE    (VEC_BASE),
        .STRIDE_SH   (STRIDE_SH)
    ) u_vec (
        .cause (win_cause),
        .entry (entry)
    );

    exc_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (take),
        .pc_in    (win_pc),
        .cause_in (win_cause),
        .epc_q    (epc_q),
        .cause_q  (cause_q)
    );

    // Flush control: the faulting stage and every younger stage.
    always_comb begin
        flush_if       = 1'b0;
        flush_id       = 1'b0;
        flush_ex       = 1'b0;
        ex_wb_suppress = 1'b0;
        unique case (sel)
            SEL_EX: begin
                flush_if       = 1'b1;
                flush_id       = 1'b1;
                flush_ex       = 1'b1;
                ex_wb_suppress = 1'b1;
            end
            SEL_ID: begin
                flush_if = 1'b1;
                flush_id = 1'b1;
            end
            default: begin
                flush_if = 1'b0;
            end
        endcase
    end

    // The handler entry outranks a branch target.
    assign redirect    = take | br_redirect;
    assign redirect_pc = take ? entry : br_target;
endmodule

// File: rtl/exc_ctrl_checker.sv
module exc_ctrl_checker #(
    parameter int          XLEN        = 32,
    parameter bit          VECTORED    = 1'b0,
    parameter logic [31:0] FIXED_ENTRY = 32'h8000_0180,
    parameter logic [31:0] VEC_BASE    = 32'hC000_0000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_valid,
    input logic            id_undef,
    input logic [XLEN-1:0] id_pc,
    input logic            ex_valid,
    input logic            ex_ovf,
    input logic [XLEN-1:0] ex_pc,
    input logic            br_redirect,
    input logic [XLEN-1:0] br_target,
    input logic            redirect,
    input logic [XLEN-1:0] redirect_pc,
    input logic            flush_if,
    input logic            flush_id,
    input logic            flush_ex,
    input logic            ex_wb_suppress,
    input logic [XLEN-1:0] epc_q,
    input logic [0:0]      cause_q
);
    logic ex_hit;
    logic id_hit;
    logic any_hit;

    assign ex_hit  = ex_valid & ex_ovf;
    assign id_hit  = id_valid & id_undef & ~ex_hit;
    assign any_hit = ex_hit | id_hit;

    assert_ex_flush_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ex_hit |-> (flush_if && flush_id && flush_ex && ex_wb_suppress && redirect));

    assert_ex_record_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ex_hit |=> (cause_q == 1'b1 && epc_q == $past(ex_pc) + XLEN'(4)));

    assert_id_keeps_ex_R3: assert property (@(posedge clk) disable iff (!rst_n)
        id_hit |-> (flush_if && flush_id && !flush_ex && !ex_wb_suppress));

    assert_id_record_R3: assert property (@(posedge clk) disable iff (!rst_n)
        id_hit |=> (cause_q == 1'b0 && epc_q == $past(id_pc) + XLEN'(4)));

    assert_hold_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |=> ($stable(epc_q) && $stable(cause_q)));

    assert_bubble_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_hit && !br_redirect) |-> (!redirect && !flush_if && !flush_id && !flush_ex));

    assert_branch_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_redirect && !any_hit) |-> (redirect && redirect_pc == br_target && !flush_if));

    assert_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ex_hit |-> (redirect_pc == (VECTORED ? XLEN'(VEC_BASE) + XLEN'(32) : XLEN'(FIXED_ENTRY))));

    assert_entry_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
        id_hit |-> (redirect_pc == (VECTORED ? XLEN'(VEC_BASE) : XLEN'(FIXED_ENTRY))));
endmodule

bind exc_ctrl_unit exc_ctrl_checker #(
    .XLEN        (XLEN),
    .VECTORED    (VECTORED),
    .FIXED_ENTRY (FIXED_ENTRY),
    .VEC_BASE    (VEC_BASE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .id_valid       (id_valid),
    .id_undef       (id_undef),
    .id_pc          (id_pc),
    .ex_valid       (ex_valid),
    .ex_ovf         (ex_ovf),
    .ex_pc          (ex_pc),
    .br_redirect    (br_redirect),
    .br_target      (br_target),
    .redirect       (redirect),
    .redirect_pc    (redirect_pc),
    .flush_if       (flush_if),
    .flush_id       (flush_id),
    .flush_ex       (flush_ex),
    .ex_wb_suppress (ex_wb_suppress),
    .epc_q          (epc_q),
    .cause_q        (cause_q)
);

// File: tb/tb_exc_ctrl_unit.sv
module tb_exc_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid = 1'b0, id_undef = 1'b0, ex_valid = 1'b0, ex_ovf = 1'b0;
    logic [31:0] id_pc = '0, ex_pc = '0, br_target = '0;
    logic        br_redirect = 1'b0;

    logic        redirect, flush_if, flush_id, flush_ex, ex_wb_suppress;
    logic [31:0] redirect_pc, epc_q;
    logic [0:0]  cause_q;
    logic        redirect_v, flush_if_v, flush_id_v, flush_ex_v, sup_v;
    logic [31:0] redirect_pc_v, epc_v;
    logic [0:0]  cause_v;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    exc_ctrl_unit #(.VECTORED(1'b0)) dut (
        .clk(clk), .rst_n(rst_n),
        .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
        .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
        .br_redirect(br_redirect), .br_target(br_target),
        .redirect(redirect), .redirect_pc(redirect_pc),
        .flush_if(flush_if), .flush_id(flush_id), .flush_ex(flush_ex),
        .ex_wb_suppress(ex_wb_suppress), .epc_q(epc_q), .cause_q(cause_q)
    );

    exc_ctrl_unit #(.VECTORED(1'b1)) dut_vec (
        .clk(clk), .rst_n(rst_n),
        .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
        .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
        .br_redirect(br_redirect), .br_target(br_target),
        .redirect(redirect_v), .redirect_pc(redirect_pc_v),
        .flush_if(flush_if_v), .flush_id(flush_id_v), .flush_ex(flush_ex_v),
        .ex_wb_suppress(sup_v), .epc_q(epc_v), .cause_q(cause_v)
    );

    typedef struct {
        string       tag;
        logic        redir;
        logic [31:0] rpc;
        logic [31:0] rpc_v;
        logic [3:0]  flags;   // {flush_if, flush_id, flush_ex, suppress}
        logic [31:0] epc;
        logic        cause;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] m_epc = '0;
    logic        m_cause = 1'b0;

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push what the ports must show.
    task automatic step(string tag, logic idv, logic idu, logic [31:0] ipc,
                        logic exv, logic exo, logic [31:0] epc_in,
                        logic br, logic [31:0] brt);
        exp_t e;
        logic hit_ex, hit_id, take, cz;
        logic [31:0] wpc;
        @(negedge clk);
        id_valid = idv; id_undef = idu; id_pc = ipc;
        ex_valid = exv; ex_ovf = exo;   ex_pc = epc_in;
        br_redirect = br; br_target = brt;
        hit_ex = exv & exo;
        hit_id = idv & idu & ~hit_ex;
        take   = hit_ex | hit_id;
        cz     = hit_ex;
        wpc    = hit_ex ? epc_in : ipc;
        e.tag   = tag;
        e.redir = take | br;
        e.rpc   = take ? 32'h8000_0180 : brt;
        e.rpc_v = take ? (cz ? 32'hC000_0020 : 32'hC000_0000) : brt;
        e.flags = hit_ex ? 4'b1111 : (hit_id ? 4'b1100 : 4'b0000);
        e.epc   = m_epc;
        e.cause = m_cause;
        sb.push_back(e);
        if (take) begin
            m_epc   = wpc + 32'd4;
            m_cause = cz;
        end
    endtask

    // Monitor: pop and compare away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.tag, "redirect", 32'(redirect), 32'(e.redir));
                cmp(e.tag, "redirect_pc", redirect_pc, e.rpc);
                cmp(e.tag, "redirect_pc_vec", redirect_pc_v, e.rpc_v);
                cmp(e.tag, "flags", 32'({flush_if, flush_id, flush_ex, ex_wb_suppress}), 32'(e.flags));
                cmp(e.tag, "flags_vec", 32'({flush_if_v, flush_id_v, flush_ex_v, sup_v}), 32'(e.flags));
                cmp(e.tag, "epc", epc_q, e.epc);
                cmp(e.tag, "cause", 32'(cause_q), 32'(e.cause));
                cmp(e.tag, "epc_vec", epc_v, e.epc);
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1_reset",      0,0,32'h0,        0,0,32'h0,        0,32'h0);
        step("R2_R6_R7_ovf",  0,0,32'h0,        1,1,32'h0000_004C, 0,32'h0);
        step("R10_hold",      0,0,32'h0,        0,0,32'h0,        0,32'h0);
        step("R3_R7_undef",   1,1,32'h0000_0100, 1,0,32'h0000_00FC, 0,32'h0);
        step("R10_hold2",     0,0,32'h0,        0,0,32'h0,        0,32'h0);
        step("R4_both",       1,1,32'h0000_0204, 1,1,32'h0000_0200, 0,32'h0);
        step("R5_bubbles",    0,1,32'h0000_0900, 0,1,32'h0000_0904, 0,32'h0);
        step("R5_after",      0,0,32'h0,        0,0,32'h0,        0,32'h0);
        step("R9_branch",     0,0,32'h0,        0,0,32'h0,        1,32'h0000_3000);
        step("R8_ovf_vs_br",  0,0,32'h0,        1,1,32'h0000_0440, 1,32'h0000_3000);
        step("R8_id_vs_br",   1,1,32'h0000_0500, 0,1,32'h0000_04FC, 1,32'h0000_3004);
        step("R2_wrap",       0,0,32'h0,        1,1,32'hFFFF_FFFC, 0,32'h0);
        step("R10_hold3",     0,0,32'h0,        0,0,32'h0,        0,32'h0);
        step("R10_idle_end",  0,0,32'h0,        0,0,32'h0,        0,32'h0);
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule